// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block holds a 64-bit up-counter that advances by one on every clock while it is enabled, and a set of comparator channels that watch it. Each channel raises a per-channel interrupt level when the counter reaches its comparator value. In one-shot mode a channel fires once for each comparator write. In periodic mode it reloads itself by a stored period at every match. Software reaches every register through a simple 32-bit word-addressed bus. Writes take effect at the clock edge, and reads return data combinationally from the register state.

A read-only capability pair reports the channel count and the tick period in femtoseconds. A global control word starts and stops the counter. It also moves channels 0 and 1 off the general interrupt outputs and onto two fixed legacy lines. Word map: 0 capability, 1 tick period, 2 global control (bit 0 run, bit 1 legacy routing), 3 interrupt status, 4/5 counter low/high. Channel i has its control word at 8+4i, its comparator low half at 9+4i and its comparator high half at 10+4i.

Top module: `evt_timer`

## Requirements
- R1: Word 0 reads the channel count minus one in bits [12:8] and a 1 in bit 15 (legacy routing capable). Word 1 reads the tick period parameter.
- R2: While word 2 bit 0 is 1, the counter (word 4 low half, word 5 high half) rises by exactly one per clock. While that bit is 0 it holds its value. Reset clears it.
- R3: A write to a counter half updates it only while the counter is halted. While the counter runs, such a write is ignored.
- R4: A comparator write arms a one-shot channel. The status bit of the channel reads 1 in the same cycle that the counter first reads the comparator value, and 0 one cycle before. After that the channel does not fire again until the comparator is written again.
- R5: A write to a comparator half reads back with the value just written.
- R6: Writing a channel control word with bit 6 (set-value) equal to 1 on a periodic-capable channel starts a sequence. The next comparator-low write loads the match value, and the comparator-low write after that loads the period and leaves the comparator unchanged.
- R7: In periodic mode (control bit 3) the comparator grows by the period in the same cycle as each match. The channel therefore fires every period ticks.
- R8: With control bit 8 (32-bit mode) equal to 1, only the low 32 bits of the counter and the comparator are compared. With it equal to 0, all 64 bits must be equal.
- R9: Status bit i (word 3) sets on a match of channel i only when control bit 2 (interrupt enable) is 1. A 1 written to a status bit clears it. A match in the same cycle wins over the clear.
- R10: irq_o[i] follows status bit i. When word 2 bit 1 is 1, status bits 0 and 1 drive legacy_irq_o[0] and legacy_irq_o[1] instead, and irq_o[1:0] stay 0.
- R11: Channel control bit 4 reads 1 on periodic-capable channels. Channel 1 reads 0 there and ignores writes to its periodic bit. Bit 6 and bit 15 always read 0, and bits [13:9] hold a route number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_we_i | input | 1 | Write strobe for the word at bus_addr_i |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | NUM_CH | Per-channel interrupt levels |
| legacy_irq_o | output | 2 | Legacy lines fed by channels 0 and 1 |

## Verification
The one-shot path is driven with random counter start values, random distances to the match and random channels. It is checked one cycle before and exactly at the expected match, which exposes an off-by-one in where the comparison happens. Directed runs put a different high counter half against the comparator. This separates 32-bit from 64-bit matching, and a run with interrupts disabled separates the match from the status update. The periodic path is loaded through the set-value write sequence and checked across two consecutive periods, together with the advanced comparator readback. This tells a same-cycle reload apart from a late one, and a correctly steered period write from one that lands in the comparator.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 64;
    localparam int HI_W      = CNT_W - DATA_W;
    localparam int ADDR_W    = 6;
    localparam int RT_W      = 5;

    localparam int A_CAP     = 0;
    localparam int A_TICK    = 1;
    localparam int A_GCFG    = 2;
    localparam int A_STS     = 3;
    localparam int A_CNTL    = 4;
    localparam int A_CNTH    = 5;
    localparam int A_CH_BASE = 8;
    localparam int CH_STRIDE = 4;

    localparam int B_IE      = 2;
    localparam int B_PER     = 3;
    localparam int B_PCAP    = 4;
    localparam int B_SV      = 6;
    localparam int B_F32     = 8;
    localparam int B_RT_LO   = 9;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_MATCH  = 2'd1,
        PH_PERIOD = 2'd2
    } sv_phase_e;

    typedef struct packed {
        logic              ie;
        logic              per;
        logic              f32;
        logic [RT_W-1:0]   route;
        sv_phase_e         ph;
        logic              armed;
        logic [CNT_W-1:0]  cmp;
        logic [DATA_W-1:0] period;
    } chan_st_t;
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cnt_nx_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            // software loads are honoured only while halted
            if (wr_lo_i) cnt_d[DATA_W-1:0]     = wdata_i;
            if (wr_hi_i) cnt_d[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_nx_i,
    input  logic              cfg_we_i,
    input  logic              cmpl_we_i,
    input  logic              cmph_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_rd_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              hit_o,
    output logic              ie_o
);
    chan_st_t st_d, st_q;
    logic     eq;
    logic     hit;

    always_comb begin
        st_d = st_q;
        eq   = st_q.f32 ? (cnt_nx_i[DATA_W-1:0] == st_q.cmp[DATA_W-1:0])
                        : (cnt_nx_i == st_q.cmp);
        hit  = run_i && eq && (st_q.armed || st_q.per);

        if (hit) begin
            if (st_q.per) begin
                // reload in the match cycle so the next period is never missed
                if (st_q.f32) st_d.cmp[DATA_W-1:0] = st_q.cmp[DATA_W-1:0] + st_q.period;
                else          st_d.cmp = st_q.cmp + CNT_W'(st_q.period);
            end else begin
                st_d.armed = 1'b0;
            end
        end

        if (cfg_we_i) begin
            st_d.ie    = wdata_i[B_IE];
            st_d.per   = wdata_i[B_PER] & PER_CAP;
            st_d.f32   = wdata_i[B_F32];
            st_d.route = wdata_i[B_RT_LO +: RT_W];
            if (wdata_i[B_SV] && PER_CAP) st_d.ph = PH_MATCH;
        end

        if (cmpl_we_i) begin
            if (st_q.ph == PH_PERIOD) begin
                st_d.period = wdata_i;
                st_d.ph     = PH_IDLE;
            end else begin
                st_d.cmp[DATA_W-1:0] = wdata_i;
                st_d.armed           = 1'b1;
                if (st_q.ph == PH_MATCH) st_d.ph = PH_PERIOD;
            end
        end

        if (cmph_we_i) begin
            st_d.cmp[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
            st_d.armed               = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rd_o                     = '0;
        cfg_rd_o[B_IE]               = st_q.ie;
        cfg_rd_o[B_PER]              = st_q.per;
        cfg_rd_o[B_PCAP]             = PER_CAP;
        cfg_rd_o[B_F32]              = st_q.f32;
        cfg_rd_o[B_RT_LO +: RT_W]    = st_q.route;
    end

    assign cmp_o = st_q.cmp;
    assign hit_o = hit;
    assign ie_o  = st_q.ie;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int                  NUM_CH       = 3,
    parameter logic [DATA_W-1:0]   TICK_FS      = 32'd69841279,
    parameter logic [NUM_CH-1:0]   PER_CAP_MASK = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic [1:0]        legacy_irq_o
);
    typedef struct packed {
        logic              en;
        logic              leg;
        logic [NUM_CH-1:0] sts;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0]  cnt_w, cnt_nx_w;
    logic [NUM_CH-1:0] hit_w, ie_w;
    logic [DATA_W-1:0] cfg_rd [NUM_CH];
    logic [CNT_W-1:0]  cmp_w  [NUM_CH];
    logic              cnt_lo_we, cnt_hi_we;
    logic [NUM_CH-1:0] leg_mask;

    assign cnt_lo_we = bus_we_i && (bus_addr_i == ADDR_W'(A_CNTL));
    assign cnt_hi_we = bus_we_i && (bus_addr_i == ADDR_W'(A_CNTH));

    evt_timer_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.en),
        .wr_lo_i  (cnt_lo_we),
        .wr_hi_i  (cnt_hi_we),
        .wdata_i  (bus_wdata_i),
        .cnt_o    (cnt_w),
        .cnt_nx_o (cnt_nx_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = A_CH_BASE + CH_STRIDE * i;
        evt_timer_chan #(.PER_CAP(PER_CAP_MASK[i])) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (st_q.en),
            .cnt_nx_i  (cnt_nx_w),
            .cfg_we_i  (bus_we_i && (bus_addr_i == ADDR_W'(BASE))),
            .cmpl_we_i (bus_we_i && (bus_addr_i == ADDR_W'(BASE + 1))),
            .cmph_we_i (bus_we_i && (bus_addr_i == ADDR_W'(BASE + 2))),
            .wdata_i   (bus_wdata_i),
            .cfg_rd_o  (cfg_rd[i]),
            .cmp_o     (cmp_w[i]),
            .hit_o     (hit_w[i]),
            .ie_o      (ie_w[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_we_i && bus_addr_i == ADDR_W'(A_GCFG)) begin
            st_d.en  = bus_wdata_i[0];
            st_d.leg = bus_wdata_i[1];
        end
        if (bus_we_i && bus_addr_i == ADDR_W'(A_STS))
            st_d.sts = st_q.sts & ~bus_wdata_i[NUM_CH-1:0];
        // a new match outranks a clear in the same cycle
        st_d.sts = st_d.sts | (hit_w & ie_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        leg_mask      = '0;
        leg_mask[1:0] = {2{st_q.leg}};
    end

    assign irq_o        = st_q.sts & ~leg_mask;
    assign legacy_irq_o = st_q.sts[1:0] & {2{st_q.leg}};

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_CAP):  begin
                bus_rdata_o[12:8] = 5'(NUM_CH - 1);
                bus_rdata_o[15]   = 1'b1;
            end
            ADDR_W'(A_TICK): bus_rdata_o = TICK_FS;
            ADDR_W'(A_GCFG): bus_rdata_o[1:0] = {st_q.leg, st_q.en};
            ADDR_W'(A_STS):  bus_rdata_o[NUM_CH-1:0] = st_q.sts;
            ADDR_W'(A_CNTL): bus_rdata_o = cnt_w[DATA_W-1:0];
            ADDR_W'(A_CNTH): bus_rdata_o = cnt_w[CNT_W-1:DATA_W];
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == ADDR_W'(A_CH_BASE + CH_STRIDE * i))     bus_rdata_o = cfg_rd[i];
            if (bus_addr_i == ADDR_W'(A_CH_BASE + CH_STRIDE * i + 1)) bus_rdata_o = cmp_w[i][DATA_W-1:0];
            if (bus_addr_i == ADDR_W'(A_CH_BASE + CH_STRIDE * i + 2)) bus_rdata_o = cmp_w[i][CNT_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              leg,
    input logic              cnt_we,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] sts,
    input logic [NUM_CH-1:0] hit,
    input logic [NUM_CH-1:0] ie,
    input logic [NUM_CH-1:0] irq
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + CNT_W'(1));

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt));

    p_sts_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts)) & ~$past(hit & ie)) == '0);

    p_legacy_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        leg |-> irq[1:0] == 2'b00);
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st_q.en),
    .leg    (st_q.leg),
    .cnt_we (cnt_lo_we | cnt_hi_we),
    .cnt    (cnt_w),
    .sts    (st_q.sts),
    .hit    (hit_w),
    .ie     (ie_w),
    .irq    (irq_o)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
    import evt_timer_pkg::*;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wd = '0;
    wire  [31:0]       rdw;
    wire  [NCH-1:0]    irq;
    wire  [1:0]        lirq;
    int                n_run = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wd), .bus_rdata_o(rdw), .irq_o(irq), .legacy_irq_o(lirq)
    );

    function automatic int a_cfg(int c);  return A_CH_BASE + CH_STRIDE * c;     endfunction
    function automatic int a_cmpl(int c); return A_CH_BASE + CH_STRIDE * c + 1; endfunction
    function automatic int a_cmph(int c); return A_CH_BASE + CH_STRIDE * c + 2; endfunction
    function automatic logic [31:0] cfg_word(bit ie, bit per, bit sv, bit f32);
        return (32'(ie) << 2) | (32'(per) << 3) | (32'(sv) << 6) | (32'(f32) << 8);
    endfunction
    function automatic logic [31:0] exp_cap0();
        return (32'(NCH - 1) << 8) | (32'd1 << 15);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask
    task automatic wr(int a, logic [31:0] d);
        addr = ADDR_W'(a); wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask
    task automatic rd(int a, output logic [31:0] d);
        addr = ADDR_W'(a);
        #0.1;
        d = rdw;
    endtask
    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    // one-shot run on channel c: counter starts at {7, base}, match after d ticks
    task automatic oneshot(int c, logic [31:0] base, int d, bit f32, bit hi_miss, bit ie);
        logic [31:0] v;
        bit fire;
        fire = ie && (f32 || !hi_miss);
        wr(A_CNTL, base);
        wr(A_CNTH, 32'd7);
        wr(a_cfg(c), cfg_word(ie, 1'b0, 1'b0, f32));
        wr(a_cmph(c), hi_miss ? 32'd0 : 32'd7);
        wr(a_cmpl(c), base + 32'(d));
        rd(a_cmpl(c), v); check("R5 cmp low readback", v, base + 32'(d));
        rd(a_cmph(c), v); check("R5 cmp high readback", v, hi_miss ? 32'd0 : 32'd7);
        wr(A_STS, 32'hFFFF_FFFF);
        wr(A_GCFG, 32'd1);
        idle(d - 1);
        rd(A_STS, v); check("R4 no status before match", v[c], 1'b0);
        idle(1);
        rd(A_CNTL, v); check("R2 counter at match", v, base + 32'(d));
        rd(A_STS, v); check(f32 ? "R8 low-half match" : (ie ? "R4 status at match" : "R9 ie off"), v[c], fire);
        check("R10 irq follows status", irq[c], fire);
        idle(3);
        wr(A_STS, 32'(1) << c);
        rd(A_STS, v); check("R9 w1c clears", v[c], 1'b0);
        idle(5);
        rd(A_STS, v); check("R4 single fire", v[c], 1'b0);
        wr(A_GCFG, 32'd0);
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20250));
        idle(3);
        rst_n = 1'b1;
        // reset state
        check("R10 irq reset", irq, '0);
        check("R10 legacy reset", lirq, 2'b00);
        rd(A_STS, v);  check("R9 status reset", v, 32'd0);
        rd(A_CNTL, v); check("R2 counter reset", v, 32'd0);
        // capability
        rd(A_CAP, v);  check("R1 capability", v, exp_cap0());
        rd(A_TICK, v); check("R1 tick period", v, 32'd69841279);
        // channel control fields
        wr(a_cfg(1), cfg_word(1, 1, 1, 0) | (32'd5 << 9));
        rd(a_cfg(1), v); check("R11 ch1 no periodic", v, 32'h4 | (32'd5 << 9));
        wr(a_cfg(1), 32'd0);
        wr(a_cfg(0), 32'h8000_0040);
        rd(a_cfg(0), v); check("R11 ch0 cap bits", v, 32'h10);
        // counter run / halt / ignored writes
        wr(A_CNTL, 32'h100);
        wr(A_CNTH, 32'h2);
        idle(3);
        rd(A_CNTL, v); check("R2 halted holds", v, 32'h100);
        rd(A_CNTH, v); check("R3 halted write high", v, 32'h2);
        wr(A_GCFG, 32'd1);
        idle(4);
        rd(A_CNTL, v); check("R2 counting", v, 32'h104);
        wr(A_CNTL, 32'hDEAD);
        rd(A_CNTL, v); check("R3 write ignored while running", v, 32'h105);
        wr(A_GCFG, 32'd0);
        rd(A_CNTL, v); check("R2 stops", v, 32'h106);
        // directed one-shot corners
        oneshot(2, 32'h1000, 5, 1'b1, 1'b1, 1'b1);   // R8 32-bit mode ignores high half
        oneshot(2, 32'h2000, 5, 1'b0, 1'b1, 1'b1);   // R8 64-bit mode needs high half
        oneshot(1, 32'h3000, 4, 1'b0, 1'b0, 1'b0);   // R9 no status without ie
        // periodic via set-value sequence on channel 0
        wr(A_CNTL, 32'd1000);
        wr(A_CNTH, 32'd0);
        wr(a_cmph(0), 32'd0);
        wr(a_cfg(0), cfg_word(1, 1, 1, 0));
        wr(a_cmpl(0), 32'd1006);
        wr(a_cmpl(0), 32'd10);
        rd(a_cmpl(0), v); check("R6 period write leaves cmp", v, 32'd1006);
        wr(A_STS, 32'hFFFF_FFFF);
        wr(A_GCFG, 32'd1);
        idle(5);
        rd(A_STS, v); check("R7 before first match", v[0], 1'b0);
        idle(1);
        rd(A_STS, v); check("R6 first match", v[0], 1'b1);
        rd(a_cmpl(0), v); check("R7 cmp advanced", v, 32'd1016);
        wr(A_STS, 32'd1);
        idle(8);
        rd(A_STS, v); check("R7 before second match", v[0], 1'b0);
        idle(1);
        rd(A_STS, v); check("R7 second match", v[0], 1'b1);
        rd(a_cmpl(0), v); check("R7 cmp advanced again", v, 32'd1026);
        wr(A_GCFG, 32'd0);
        // legacy routing
        wr(A_GCFG, 32'd2);
        check("R10 legacy line 0", lirq[0], 1'b1);
        check("R10 irq0 masked", irq[0], 1'b0);
        wr(A_GCFG, 32'd0);
        check("R10 irq0 restored", irq[0], 1'b1);
        check("R10 legacy off", lirq, 2'b00);
        wr(A_STS, 32'hFFFF_FFFF);
        // random one-shot runs
        for (int k = 0; k < 24; k++) begin
            int c;
            bit f;
            c = int'($urandom_range(NCH - 1, 0));
            f = 1'($urandom_range(1, 0));
            oneshot(c, $urandom_range(32'hEFFF_FFFF, 32'h0), int'($urandom_range(30, 2)),
                    f, f ? 1'($urandom_range(1, 0)) : 1'b0, 1'b1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule